// File: doc/BRIEF.md
# Two-Phase Processor Clock Sequencer

This block turns one fast reference clock into the two non-overlapping clock phases that an older two-phase processor core expects. A modulo-nine counter runs on the reference clock. Each nine-period processor cycle opens with phase one high for two reference periods. Phase two is then high for five periods, and both phases stay low for the last two. The block also brings out the reference clock itself, so other timing can be derived from it, and a second phase-two output that external bus masters use to gate themselves onto the bus once the processor has acknowledged a hold.

The same counter handles three control signals:
- A ready request may arrive at any time. It is synchronised and then allowed onto the ready output only at the reference edge that closes phase two, so the processor never sees ready move while phase two is high.
- The processor's sync flag is sampled at that same edge. When it is set, an active-low status strobe covers the phase-one window of the next cycle.
- While reset is held, the strobe is forced active so that a downstream status latch clears. A registered reset output follows the reset input, and it changes only when the counter is at the start of a cycle.

Reset enters as a clean synchronous active-high input.

Top module: `twoPhaseSeq`

## Requirements
- R1: Once running, phase one rises exactly once in every nine reference periods, and the internal count never leaves the range 0 to 8.
- R2: Phase one is high for exactly two reference periods, at counts 0 and 1 of each cycle.
- R3: Phase two goes high on the same reference edge that ends phase one, and it stays high for exactly five reference periods (counts 2 to 6).
- R4: Both phases are low for the last two reference periods of the cycle (counts 7 and 8), and the two phases are never high together.
- R5: The oscillator output is the reference clock passed through without a register: low while the reference is low, and high while it is high.
- R6: The phase-two copy output equals phase two in every reference period.
- R7: The ready request passes through two reference-clock flip-flops. The ready output takes the value of the second flip-flop only on the rising reference edge where phase two falls (count 6 to 7), and it holds at every other edge.
- R8: The status strobe is active low. While running, it is low for exactly the two phase-one periods of a cycle if the sync input was high at the edge that ended phase two in the previous cycle. Otherwise it is high.
- R9: From the first edge at which reset is sampled high until the first edge at which it is sampled low, the status strobe is held low.
- R10: An edge that samples reset high puts the count at 0 and drives both phases low. The first edge that samples reset low starts a full cycle: phase one is then high for the next two periods.
- R11: The reset output is registered. It goes high at the first edge that samples reset high, goes low at the first edge that samples reset low, and changes only at edges where the count ends up at 0.
- R12: The ready output, the synchroniser flip-flops and the stored sync flag clear while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Fast reference clock (stands in for the crystal oscillator) |
| rstIn | input | 1 | Synchronous active-high reset |
| readyReq | input | 1 | Asynchronous ready/wait request, high means ready |
| syncIn | input | 1 | Processor flag marking the start of a machine cycle |
| oscOut | output | 1 | Buffered reference clock |
| phi1 | output | 1 | Processor clock phase one |
| phi2 | output | 1 | Processor clock phase two |
| phi2Copy | output | 1 | Copy of phase two for bus-gating logic |
| readyOut | output | 1 | Ready output, synchronised to the phases |
| statusStrobeN | output | 1 | Active-low status strobe |
| rstOut | output | 1 | Registered reset output, aligned to cycle boundaries |

## Verification
The phases, strobe and reset output come from registered state, so each one reflects the edge just before it with no further delay. A ready request that is stable before an edge reaches the second synchroniser flip-flop one edge later. It then waits for the next count-6-to-7 edge, so readyOut moves between two and about ten edges after the request. The bench keeps a cycle-accurate model that is updated on every rising edge from the stimulus it has applied, and it compares every output on the falling edge, half a period after the registers settle. Ready requests are changed at random offsets between edges, so the gating edge is exercised at many different phases. Run lengths of phase one, phase two, the gap and the full cycle are measured independently of the model.

// File: rtl/twoPhaseSeq_pkg.sv
package twoPhaseSeq_pkg;

  // Per-period decode handed from the counter to the output logic
  typedef struct packed {
    logic inPhi1;      // count is inside the phase-one window
    logic inPhi2;      // count is inside the phase-two window
    logic endPhi2;     // the next edge closes phase two
    logic cycleStart;  // the next edge lands on count 0 (or idle)
    logic running;     // counter is out of reset
  } seqStrobes_t;

endpackage

// File: rtl/phaseCtl.sv
module phaseCtl
  import twoPhaseSeq_pkg::*;
#(
  parameter int PHI1_LEN = 2,
  parameter int PHI2_LEN = 5,
  parameter int GAP_LEN  = 2
) (
  input  logic refClk,
  input  logic rstIn,
  output logic [$clog2(PHI1_LEN+PHI2_LEN+GAP_LEN)-1:0] cntQ,
  output seqStrobes_t strobes
);

  localparam int CYCLE_LEN = PHI1_LEN + PHI2_LEN + GAP_LEN;
  localparam int CNT_W     = $clog2(CYCLE_LEN);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CYCLE_LEN - 1);
  localparam logic [CNT_W-1:0] PHI2_BEG  = CNT_W'(PHI1_LEN);
  localparam logic [CNT_W-1:0] PHI2_LAST = CNT_W'(PHI1_LEN + PHI2_LEN - 1);

  logic runQ;
  logic atLast;

  assign atLast = (cntQ == LAST_CNT);

  // Counter holds at 0 for one edge after reset release so phase one gets full length
  always_ff @(posedge refClk) begin
    if (rstIn) begin
      runQ <= 1'b0;
      cntQ <= '0;
    end else begin
      runQ <= 1'b1;
      if (runQ) begin
        if (atLast) cntQ <= '0;
        else        cntQ <= cntQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.running    = runQ;
    strobes.inPhi1     = runQ && (cntQ < PHI2_BEG);
    strobes.inPhi2     = runQ && (cntQ >= PHI2_BEG) && (cntQ <= PHI2_LAST);
    strobes.endPhi2    = runQ && (cntQ == PHI2_LAST);
    strobes.cycleStart = !runQ || atLast;
  end

endmodule

// File: rtl/phaseData.sv
module phaseData
  import twoPhaseSeq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        refClk,
  input  logic        rstIn,
  input  logic        readyReq,
  input  logic        syncIn,
  input  seqStrobes_t strobes,
  output logic        phi1,
  output logic        phi2,
  output logic        phi2Copy,
  output logic        readyOut,
  output logic        statusStrobeN,
  output logic        rstOut
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic syncSeenQ;
  logic readyQ;
  logic rstOutQ;

  // Synchroniser for the asynchronous ready request
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge refClk) begin
          if (rstIn) syncChain[0] <= 1'b0;
          else       syncChain[0] <= readyReq;
        end
      end else begin : gNext
        always_ff @(posedge refClk) begin
          if (rstIn) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  // Ready and sync capture happen only on the edge that closes phase two
  always_ff @(posedge refClk) begin
    if (rstIn) begin
      readyQ    <= 1'b0;
      syncSeenQ <= 1'b0;
    end else if (strobes.endPhi2) begin
      readyQ    <= syncChain[SYNC_STAGES-1];
      syncSeenQ <= syncIn;
    end
  end

  // Reset output moves only where the count lands on the cycle start
  always_ff @(posedge refClk) begin
    if (rstIn)                   rstOutQ <= 1'b1;
    else if (strobes.cycleStart) rstOutQ <= 1'b0;
  end

  assign phi1          = strobes.inPhi1;
  assign phi2          = strobes.inPhi2;
  assign phi2Copy      = strobes.inPhi2;
  assign readyOut      = readyQ;
  assign rstOut        = rstOutQ;
  assign statusStrobeN = !(!strobes.running || (syncSeenQ && strobes.inPhi1));

endmodule

// File: rtl/twoPhaseSeq.sv
module twoPhaseSeq
  import twoPhaseSeq_pkg::*;
#(
  parameter int PHI1_LEN    = 2,
  parameter int PHI2_LEN    = 5,
  parameter int GAP_LEN     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstIn,
  input  logic readyReq,
  input  logic syncIn,
  output logic oscOut,
  output logic phi1,
  output logic phi2,
  output logic phi2Copy,
  output logic readyOut,
  output logic statusStrobeN,
  output logic rstOut
);

  localparam int CNT_W = $clog2(PHI1_LEN + PHI2_LEN + GAP_LEN);

  seqStrobes_t strobes;
  logic [CNT_W-1:0] cntQ;

  assign oscOut = refClk;

  phaseCtl #(
    .PHI1_LEN(PHI1_LEN),
    .PHI2_LEN(PHI2_LEN),
    .GAP_LEN (GAP_LEN)
  ) i_phaseCtl (
    .refClk (refClk),
    .rstIn  (rstIn),
    .cntQ   (cntQ),
    .strobes(strobes)
  );

  phaseData #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_phaseData (
    .refClk       (refClk),
    .rstIn        (rstIn),
    .readyReq     (readyReq),
    .syncIn       (syncIn),
    .strobes      (strobes),
    .phi1         (phi1),
    .phi2         (phi2),
    .phi2Copy     (phi2Copy),
    .readyOut     (readyOut),
    .statusStrobeN(statusStrobeN),
    .rstOut       (rstOut)
  );

endmodule

// File: rtl/twoPhaseSeq_chk.sv
module twoPhaseSeq_chk #(
  parameter int CNT_W = 4
) (
  input logic             refClk,
  input logic             rstIn,
  input logic             phi1,
  input logic             phi2,
  input logic             phi2Copy,
  input logic             readyOut,
  input logic             statusStrobeN,
  input logic             rstOut,
  input logic [CNT_W-1:0] cntQ
);

  assert_count_range_R1: assert property (@(posedge refClk) disable iff (rstIn)
    cntQ <= CNT_W'(8));

  assert_phi1_two_R2: assert property (@(posedge refClk) disable iff (rstIn)
    $rose(phi1) |=> phi1);

  assert_phi2_follows_R3: assert property (@(posedge refClk) disable iff (rstIn)
    $fell(phi1) |-> phi2);

  assert_no_overlap_R4: assert property (@(posedge refClk) disable iff (rstIn)
    !(phi1 && phi2));

  assert_copy_match_R6: assert property (@(posedge refClk) disable iff (rstIn)
    phi2Copy == phi2);

  assert_ready_gate_R7: assert property (@(posedge refClk) disable iff (rstIn)
    (readyOut != $past(readyOut)) |-> $fell(phi2));

  assert_strobe_window_R8: assert property (@(posedge refClk) disable iff (rstIn)
    (!statusStrobeN && !$past(rstIn)) |-> phi1);

  assert_rst_boundary_R11: assert property (@(posedge refClk) disable iff (rstIn)
    (rstOut != $past(rstOut)) |-> (cntQ == '0));

endmodule

bind twoPhaseSeq twoPhaseSeq_chk #(.CNT_W(CNT_W)) i_twoPhaseSeq_chk (
  .refClk       (refClk),
  .rstIn        (rstIn),
  .phi1         (phi1),
  .phi2         (phi2),
  .phi2Copy     (phi2Copy),
  .readyOut     (readyOut),
  .statusStrobeN(statusStrobeN),
  .rstOut       (rstOut),
  .cntQ         (cntQ)
);

// File: tb/test_twoPhaseSeq.sv
module test_twoPhaseSeq;

  localparam int CLK_PERIOD = 10;

  logic refClk = 1'b0;
  logic rstIn = 1'b1;
  logic readyReq = 1'b0;
  logic syncIn = 1'b0;
  logic oscOut, phi1, phi2, phi2Copy, readyOut, statusStrobeN, rstOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit stimOn = 1'b0;
  bit checkEn = 1'b0;

  always #(CLK_PERIOD/2) refClk = ~refClk;

  twoPhaseSeq i_twoPhaseSeq (
    .refClk(refClk), .rstIn(rstIn), .readyReq(readyReq), .syncIn(syncIn),
    .oscOut(oscOut), .phi1(phi1), .phi2(phi2), .phi2Copy(phi2Copy),
    .readyOut(readyOut), .statusStrobeN(statusStrobeN), .rstOut(rstOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle model derived from the requirements, advanced on each rising edge
  bit mRun = 0, mS1 = 0, mS2 = 0, mReady = 0, mSeen = 0, mRstOut = 1;
  int mCnt = 0;
  always @(posedge refClk) begin
    if (rstIn) begin
      mRun <= 0; mCnt <= 0; mS1 <= 0; mS2 <= 0;      // R10 R12
      mReady <= 0; mSeen <= 0; mRstOut <= 1;
    end else begin
      mRun <= 1;
      if (mRun) mCnt <= (mCnt == 8) ? 0 : mCnt + 1;
      mS1 <= readyReq; mS2 <= mS1;
      if (mRun && mCnt == 6) begin mReady <= mS2; mSeen <= syncIn; end
      if (!mRun || mCnt == 8) mRstOut <= 0;
    end
  end

  // Independent run-length measurement
  bit pPhi1 = 0, pPhi2 = 0, gapValid = 0, perValid = 0;
  int l1 = 0, l2 = 0, lg = 0, per = 0;

  always @(negedge refClk) begin
    if (checkEn) begin
      bit e1, e2;
      e1 = mRun && mCnt < 2;
      e2 = mRun && mCnt >= 2 && mCnt <= 6;
      check("R2 phi1", phi1, e1);
      check("R3 phi2", phi2, e2);
      check("R4 overlap", phi1 && phi2, 0);
      check("R6 phi2Copy", phi2Copy, phi2);
      check("R5 oscOut low", oscOut, 0);
      check("R7 readyOut", readyOut, mReady);
      check(mRun ? "R8 strobe" : "R9 strobe", statusStrobeN,
            !(!mRun || (mSeen && mCnt < 2)));
      check("R11 rstOut", rstOut, mRstOut);
      if (!mRun) check("R12 ready clear", readyOut, 0);

      if (!mRun) begin
        gapValid = 0; perValid = 0; l1 = 0; l2 = 0; lg = 0;
      end else begin
        per++;
        if (phi1 && !pPhi1) begin
          if (perValid) check("R1 period", per, 9);
          if (gapValid) check("R4 gap length", lg, 2);
          per = 0; perValid = 1; gapValid = 0;
        end
        if (phi1) l1++;
        if (!phi1 && pPhi1) begin
          check("R2 phi1 length", l1, 2);
          check("R3 phi2 follows phi1", phi2, 1);
          l1 = 0;
        end
        if (phi2) l2++;
        if (!phi2 && pPhi2) begin
          check("R3 phi2 length", l2, 5);
          l2 = 0; lg = 0; gapValid = 1;
        end
        if (!phi1 && !phi2) lg++;
      end
      pPhi1 = phi1; pPhi2 = phi2;
    end
  end

  // Ready requests at random offsets between edges
  initial begin
    while (!done) begin
      @(negedge refClk);
      if (stimOn) begin
        #($urandom_range(1, 4));
        if ($urandom_range(0, 5) == 0) readyReq = ~readyReq;
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    @(posedge refClk);
    #1 checkEn = 1;
    repeat (4) @(negedge refClk);
    // R9 R10 R11: reset state
    check("R10 phi1 in reset", phi1, 0);
    check("R9 strobe in reset", statusStrobeN, 0);
    check("R11 rstOut in reset", rstOut, 1);
    rstIn = 0;
    @(posedge refClk); #1;
    check("R10 phi1 starts", phi1, 1);
    check("R11 rstOut released", rstOut, 0);
    check("R5 oscOut high", oscOut, 1);
    stimOn = 1;
    for (int c = 0; c < 400; c++) begin
      @(negedge refClk);
      syncIn = ($urandom_range(0, 2) == 0);
      if (c == 157 || c == 311) begin
        rstIn = 1;
        repeat (3) @(negedge refClk);
        rstIn = 0;
      end
    end
    // R7: hold the request high long enough that it must propagate
    readyReq = 1; stimOn = 0;
    repeat (30) @(negedge refClk);
    check("R7 ready settled high", readyOut, 1);
    readyReq = 0;
    repeat (30) @(negedge refClk);
    check("R7 ready settled low", readyOut, 0);
    // R8: force sync high every cycle, then low
    syncIn = 1;
    repeat (40) @(negedge refClk);
    syncIn = 0;
    repeat (30) @(negedge refClk);
    check("R8 strobe idle high", statusStrobeN, 1);
    finishRun();
  end

endmodule